// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one translation entry from a flat page table in memory. A requester presents a virtual address and an access kind, read or write, with a valid/ready handshake. The walker latches the request together with the current table base and table length. It rejects page numbers outside the table without touching memory. Otherwise it issues a single one-word read for the entry and judges the returned word.

Each walk ends with a one-cycle result carrying a two-bit fault code, the frame number and the assembled physical address. The code reports one of four outcomes: success, out-of-range page, entry not present, or write to a page without write permission. The walker keeps no translation state between walks. A context switch therefore only needs new values on the base and length inputs before the next request.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1 and both `res_valid` and `mem_req_valid` are 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1. From that edge until the edge after `res_valid`, `req_ready` is 0, and any request offered meanwhile is ignored.
- R3: If the page number (virtual address bits above the low OFF_W offset bits) is greater than or equal to the sampled `pt_len`, the result has fault code 2'b01. No memory read is issued, and `res_valid` rises two clock edges after acceptance.
- R4: Every walk that passes the length check issues exactly one memory read, at `pt_base + page_number * ENTRY_BYTES`. `pt_base` and `pt_len` are sampled at acceptance, so later changes do not affect the walk in flight.
- R5: Entry word format: bit 0 = present, bit 1 = writable, bits [FRAME_W+1:2] = frame number. Bits above the frame field are ignored.
- R6: An entry with bit 0 clear gives fault code 2'b10 for both reads and writes. This check takes priority over the write-permission check.
- R7: A write to a present entry with bit 1 clear gives fault code 2'b11. A read of the same entry succeeds.
- R8: On success the fault code is 2'b00, `res_frame` is the entry's frame field, and `res_paddr` is the frame concatenated with the unchanged offset. On any fault, `res_frame` and `res_paddr` are 0.
- R9: `res_valid` is a single-cycle pulse, and there is exactly one pulse per accepted request.
- R10: `mem_req_valid` stays 1 with a stable `mem_req_addr` until `mem_req_ready` is seen. The response is taken on the first `mem_rsp_valid` after the address handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| pt_base | input | MEM_ADDR_W | Byte address of the table start |
| pt_len | input | VPN_W+1 | Number of entries in the table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read address |
| mem_req_addr | output | MEM_ADDR_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | WORD_W | Entry word |
| res_valid | output | 1 | Walk result pulse |
| res_fault | output | 2 | 00 ok, 01 range, 10 not present, 11 write-protected |
| res_frame | output | FRAME_W | Translated frame number |
| res_paddr | output | PA_W | Physical address |

## Verification
The bound checker watches, on every cycle:
- that the ready signal stays low for the whole of a walk;
- that results appear only as single pulses inside a walk;
- that a pending memory read holds its address;
- the read count behind each result: none for a range fault, exactly one otherwise;
- that a faulted result carries a zero address.

The checker cannot see which fault code, frame or entry address a given table word should produce. Only the bench scenarios show that: present/writable combinations, range boundaries at zero and full length, a stalled memory, inputs disturbed mid-walk, and upper entry bits that must be ignored.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_CHECK,
      WS_READ_REQ,
      WS_WAIT_RESP,
      WS_DONE
   } walk_state_e;

   localparam logic [1:0] FLT_NONE    = 2'b00;
   localparam logic [1:0] FLT_RANGE   = 2'b01;
   localparam logic [1:0] FLT_ABSENT  = 2'b10;
   localparam logic [1:0] FLT_WRPROT  = 2'b11;

   localparam int ENT_PRESENT_BIT = 0;
   localparam int ENT_WRITE_BIT   = 1;
   localparam int ENT_FRAME_LSB   = 2;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
   parameter int VPN_W       = 8,
   parameter int MEM_ADDR_W  = 24,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [VPN_W-1:0]      vpn,
   input  logic [MEM_ADDR_W-1:0] base,
   input  logic [VPN_W:0]        limit,
   output logic                  in_range,
   output logic [MEM_ADDR_W-1:0] ent_addr
);
   localparam int SCALE_SH = $clog2(ENTRY_BYTES);

   logic [MEM_ADDR_W-1:0] vpn_ext;

   assign vpn_ext  = MEM_ADDR_W'(vpn);
   assign in_range = ({1'b0, vpn} < limit);

   generate
      if (SCALE_SH == 0) begin : g_byte_entry
         assign ent_addr = base + vpn_ext;
      end else begin : g_scaled_entry
         assign ent_addr = base + (vpn_ext << SCALE_SH);
      end
   endgenerate

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
   import pt_walker_pkg::*;
#(
   parameter int FRAME_W = 12
) (
   input  logic [FRAME_W+1:0] entry,
   input  logic               is_write,
   output logic [1:0]         fault,
   output logic [FRAME_W-1:0] frame
);
   logic present;
   logic writable;

   assign present  = entry[ENT_PRESENT_BIT];
   assign writable = entry[ENT_WRITE_BIT];

   always_comb begin
      if (!present) begin
         fault = FLT_ABSENT;
      end else if (is_write && !writable) begin
         fault = FLT_WRPROT;
      end else begin
         fault = FLT_NONE;
      end
      frame = (fault == FLT_NONE) ? entry[ENT_FRAME_LSB +: FRAME_W] : '0;
   end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walker_pkg::*;
#(
   parameter int VA_W        = 16,
   parameter int OFF_W       = 8,
   parameter int PA_W        = 20,
   parameter int MEM_ADDR_W  = 24,
   parameter int WORD_W      = 32,
   parameter int ENTRY_BYTES = 4,
   localparam int VPN_W      = VA_W - OFF_W,
   localparam int FRAME_W    = PA_W - OFF_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [VA_W-1:0]       req_vaddr,
   input  logic                  req_write,
   input  logic [MEM_ADDR_W-1:0] pt_base,
   input  logic [VPN_W:0]        pt_len,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [MEM_ADDR_W-1:0] mem_req_addr,
   input  logic                  mem_rsp_valid,
   input  logic [WORD_W-1:0]     mem_rsp_data,
   output logic                  res_valid,
   output logic [1:0]            res_fault,
   output logic [FRAME_W-1:0]    res_frame,
   output logic [PA_W-1:0]       res_paddr
);
   localparam int ENT_USED_W = FRAME_W + 2;

   generate
      if (VA_W <= OFF_W) begin : g_bad_va
         $error("pt_walker: VA_W must exceed OFF_W");
      end
      if (PA_W <= OFF_W) begin : g_bad_pa
         $error("pt_walker: PA_W must exceed OFF_W");
      end
      if (WORD_W < ENT_USED_W) begin : g_bad_word
         $error("pt_walker: entry word too narrow for frame and flags");
      end
      if ((ENTRY_BYTES < 1) || ((ENTRY_BYTES & (ENTRY_BYTES - 1)) != 0)) begin : g_bad_ent
         $error("pt_walker: ENTRY_BYTES must be a power of two");
      end
      if (MEM_ADDR_W < VPN_W + $clog2(ENTRY_BYTES)) begin : g_bad_maddr
         $error("pt_walker: MEM_ADDR_W too small for table index");
      end
   endgenerate

   walk_state_e           state_q;
   logic [VA_W-1:0]       vaddr_q;
   logic                  write_q;
   logic [MEM_ADDR_W-1:0] base_q;
   logic [VPN_W:0]        limit_q;
   logic [MEM_ADDR_W-1:0] addr_q;
   logic [1:0]            fault_q;
   logic [FRAME_W-1:0]    frame_q;

   logic                  in_range;
   logic [MEM_ADDR_W-1:0] ent_addr;
   logic [1:0]            ent_fault;
   logic [FRAME_W-1:0]    ent_frame;

   pt_addr_gen #(
      .VPN_W       (VPN_W),
      .MEM_ADDR_W  (MEM_ADDR_W),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) u_addr_gen (
      .vpn      (vaddr_q[VA_W-1:OFF_W]),
      .base     (base_q),
      .limit    (limit_q),
      .in_range (in_range),
      .ent_addr (ent_addr)
   );

   pt_entry_eval #(
      .FRAME_W (FRAME_W)
   ) u_entry_eval (
      .entry    (mem_rsp_data[ENT_USED_W-1:0]),
      .is_write (write_q),
      .fault    (ent_fault),
      .frame    (ent_frame)
   );

   generate
      if (WORD_W > ENT_USED_W) begin : g_spare_bits
         logic unused_entry_hi;
         assign unused_entry_hi = ^mem_rsp_data[WORD_W-1:ENT_USED_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         vaddr_q <= '0;
         write_q <= 1'b0;
         base_q  <= '0;
         limit_q <= '0;
         addr_q  <= '0;
         fault_q <= FLT_NONE;
         frame_q <= '0;
      end else begin
         unique case (state_q)
            WS_IDLE: begin
               if (req_valid) begin
                  vaddr_q <= req_vaddr;
                  write_q <= req_write;
                  base_q  <= pt_base;
                  limit_q <= pt_len;
                  state_q <= WS_CHECK;
               end
            end
            WS_CHECK: begin
               if (in_range) begin
                  addr_q  <= ent_addr;
                  state_q <= WS_READ_REQ;
               end else begin
                  fault_q <= FLT_RANGE;
                  frame_q <= '0;
                  state_q <= WS_DONE;
               end
            end
            WS_READ_REQ: begin
               if (mem_req_ready) begin
                  state_q <= WS_WAIT_RESP;
               end
            end
            WS_WAIT_RESP: begin
               if (mem_rsp_valid) begin
                  fault_q <= ent_fault;
                  frame_q <= ent_frame;
                  state_q <= WS_DONE;
               end
            end
            WS_DONE: begin
               state_q <= WS_IDLE;
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == WS_IDLE);
   assign mem_req_valid = (state_q == WS_READ_REQ);
   assign mem_req_addr  = addr_q;
   assign res_valid     = (state_q == WS_DONE);
   assign res_fault     = fault_q;
   assign res_frame     = frame_q;
   assign res_paddr     = (fault_q == FLT_NONE) ? {frame_q, vaddr_q[OFF_W-1:0]} : '0;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int MEM_ADDR_W = 24,
   parameter int PA_W       = 20
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic                  mem_req_valid,
   input logic                  mem_req_ready,
   input logic [MEM_ADDR_W-1:0] mem_req_addr,
   input logic                  res_valid,
   input logic [1:0]            res_fault,
   input logic [PA_W-1:0]       res_paddr
);
   logic       busy_q;
   logic [1:0] rd_cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         rd_cnt_q <= '0;
      end else begin
         if (req_valid && req_ready) begin
            busy_q   <= 1'b1;
            rd_cnt_q <= '0;
         end else begin
            if (res_valid) busy_q <= 1'b0;
            if (mem_req_valid && mem_req_ready && rd_cnt_q != 2'd3)
               rd_cnt_q <= rd_cnt_q + 2'd1;
         end
      end
   end

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !req_ready);                                                // R2
   AST_RESULT_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> busy_q);                                                 // R9
   AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);                                             // R9
   AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !mem_req_valid);                                           // R4
   AST_RANGE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault == 2'b01) |-> (rd_cnt_q == 2'd0));             // R3
   AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault != 2'b01) |-> (rd_cnt_q == 2'd1));             // R4
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
   AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault != 2'b00) |-> (res_paddr == '0));              // R8

endmodule

bind pt_walker pt_walker_chk #(
   .MEM_ADDR_W (MEM_ADDR_W),
   .PA_W       (PA_W)
) u_pt_walker_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .res_valid     (res_valid),
   .res_fault     (res_fault),
   .res_paddr     (res_paddr)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
   localparam int VA_W = 16, OFF_W = 8, PA_W = 20, MEM_ADDR_W = 24, WORD_W = 32;
   localparam int VPN_W = VA_W - OFF_W, FRAME_W = PA_W - OFF_W;

   typedef struct packed {
      logic [15:0] vaddr;
      logic        wr;
      logic [23:0] base;
      logic [8:0]  limit;
      logic [31:0] entry;
      logic [1:0]  fault;
      logic [19:0] paddr;
   } vec_t;

   localparam int NVEC = 11;
   localparam vec_t VECS [0:NVEC-1] = '{
      '{16'h0355, 1'b0, 24'h001000, 9'd16,  32'h00002AF3, 2'b00, 20'hABC55},
      '{16'h0A01, 1'b1, 24'h001000, 9'd16,  32'h0000048F, 2'b00, 20'h12301},
      '{16'h0210, 1'b1, 24'h001000, 9'd16,  32'h00001159, 2'b11, 20'h00000},
      '{16'h0210, 1'b0, 24'h001000, 9'd16,  32'h00001159, 2'b00, 20'h45610},
      '{16'h0777, 1'b0, 24'h200000, 9'd16,  32'h00002AF2, 2'b10, 20'h00000},
      '{16'h0777, 1'b1, 24'h200000, 9'd16,  32'h00002AF0, 2'b10, 20'h00000},
      '{16'h1000, 1'b0, 24'h001000, 9'd16,  32'h00002AF3, 2'b01, 20'h00000},
      '{16'h0FFF, 1'b0, 24'h0FFFF0, 9'd16,  32'h00003FFD, 2'b00, 20'hFFFFF},
      '{16'h0000, 1'b1, 24'h001000, 9'd0,   32'h00002AF3, 2'b01, 20'h00000},
      '{16'hFF80, 1'b1, 24'h300000, 9'd256, 32'h00000007, 2'b00, 20'h00180},
      '{16'h0122, 1'b0, 24'h001000, 9'd16,  32'hFFFF03C1, 2'b00, 20'h0F022}
   };

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  req_valid = 1'b0;
   logic                  req_ready;
   logic [VA_W-1:0]       req_vaddr = '0;
   logic                  req_write = 1'b0;
   logic [MEM_ADDR_W-1:0] pt_base = '0;
   logic [VPN_W:0]        pt_len = '0;
   logic                  mem_req_valid;
   logic                  mem_req_ready = 1'b1;
   logic [MEM_ADDR_W-1:0] mem_req_addr;
   logic                  mem_rsp_valid = 1'b0;
   logic [WORD_W-1:0]     mem_rsp_data = '0;
   logic                  res_valid;
   logic [1:0]            res_fault;
   logic [FRAME_W-1:0]    res_frame;
   logic [PA_W-1:0]       res_paddr;

   int n_checks = 0;
   int n_fail = 0;
   int rd_count = 0;
   int stall_n = 0;
   logic [MEM_ADDR_W-1:0] rd_addr = '0;
   logic [WORD_W-1:0]     mem_word = '0;
   bit pend = 1'b0;

   always #4 clk = ~clk;

   pt_walker u_pt_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_write(req_write), .pt_base(pt_base), .pt_len(pt_len),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .res_valid(res_valid), .res_fault(res_fault), .res_frame(res_frame), .res_paddr(res_paddr)
   );

   // memory model: one-cycle response after address handshake, optional stall
   initial begin
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_word;
            pend = 1'b0;
         end
         if (mem_req_valid) begin
            if (stall_n > 0) begin
               mem_req_ready = 1'b0;
               stall_n--;
            end else begin
               mem_req_ready = 1'b1;
               rd_count++;
               rd_addr = mem_req_addr;
               pend = 1'b1;
            end
         end else begin
            mem_req_ready = 1'b1;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic string fault_tag(input logic [1:0] f);
      case (f)
         2'b01:   return "R3";
         2'b10:   return "R6";
         2'b11:   return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic do_walk(input vec_t v, input bit noise, input int stall);
      int lat;
      logic [MEM_ADDR_W-1:0] exp_addr;
      exp_addr = v.base + MEM_ADDR_W'({v.vaddr[15:8], 2'b00});
      mem_word = v.entry;
      stall_n  = stall;
      rd_count = 0;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = v.vaddr; req_write = v.wr;
      pt_base = v.base; pt_len = v.limit;
      @(negedge clk);
      req_valid = noise;
      req_vaddr = ~v.vaddr; req_write = ~v.wr;
      pt_base = ~v.base; pt_len = v.limit ^ 9'h1FF;
      check(req_ready == 1'b0, "R2 ready low in walk", 32'(req_ready), 32'd0);
      lat = 0;
      while (!res_valid && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      req_valid = 1'b0;
      check(res_valid == 1'b1, "R9 result arrives", 32'(res_valid), 32'd1);
      check(res_fault == v.fault, fault_tag(v.fault), 32'(res_fault), 32'(v.fault));
      check(res_paddr == v.paddr, "R8 paddr", 32'(res_paddr), 32'(v.paddr));
      check(res_frame == v.paddr[19:8], "R5 frame field", 32'(res_frame), 32'(v.paddr[19:8]));
      if (v.fault == 2'b01) begin
         check(rd_count == 0, "R3 no read on range fault", 32'(rd_count), 32'd0);
         check(lat == 1, "R3 range fault latency", 32'(lat), 32'd1);
      end else begin
         check(rd_count == 1, "R4 single read", 32'(rd_count), 32'd1);
         check(rd_addr == exp_addr, "R4 entry address", 32'(rd_addr), 32'(exp_addr));
      end
      @(negedge clk);
      check(res_valid == 1'b0, "R9 single-cycle result", 32'(res_valid), 32'd0);
      check(req_ready == 1'b1, "R2 ready after result", 32'(req_ready), 32'd1);
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
      check(res_valid == 1'b0, "R1 reset result", 32'(res_valid), 32'd0);
      check(mem_req_valid == 1'b0, "R1 reset mem req", 32'(mem_req_valid), 32'd0);

      for (int i = 0; i < NVEC; i++) begin
         do_walk(VECS[i], 1'b0, 0);
      end

      // R2: request held high during a walk is not taken
      do_walk(VECS[1], 1'b1, 0);
      @(negedge clk);
      check(mem_req_valid == 1'b0 && req_ready == 1'b1, "R2 busy request ignored",
            32'({mem_req_valid, req_ready}), 32'h1);

      // R10: memory stalls the address handshake
      do_walk(VECS[9], 1'b0, 3);
      do_walk(VECS[7], 1'b1, 5);

      // R4: a new base selects a new table with no other change
      do_walk('{16'h0355, 1'b0, 24'h7F0000, 9'd16, 32'h00000015, 2'b00, 20'h00555}, 1'b0, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule